// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the filtered logic level of a set of general-purpose pins into per-pin interrupt status bits and interrupt requests. Each pin owns a small sense configuration: a trigger-type bit choosing edge or level detection and a two-bit active-level field choosing low/falling, high/rising or both edges. Two independent controls govern each pin. The enable bit decides whether detection may set the status bit. The mask bit decides whether a set status bit reaches the request output.

Status is sticky. A one-cycle clear strobe drops it, and any change to the pin's sense configuration drops it as well. Software typically enables a pin by raising both enable and mask, and masks it during service by lowering only the mask. It acknowledges the event with a clear strobe. The block holds no software-visible registers of its own: the surrounding register file drives the configuration inputs and the clear strobes.

Top module: `gpio_irq_detect`

## Requirements
- R1: While the synchronous active-low reset is asserted, and on the first cycle after it, every status bit and every request is 0.
- R2: With trigger bit 0 (edge), the active-level code selects the event: 00 is a falling edge, 01 a rising edge, 10 either edge, and 11 never detects. An edge is a difference between the level sampled at a clock edge and the level sampled at the previous clock edge.
- R3: With trigger bit 1 (level), code 00 detects a sampled low level and code 01 a sampled high level. Codes 10 and 11 never detect.
- R4: A detected event sets the status bit, visible after that clock edge, only if the enable bit is 1 at that edge.
- R5: The request equals status AND mask, combinationally. A mask of 0 blocks the request but does not stop status from being set.
- R6: Once set, status stays 1 until a clear strobe or a configuration change. A clear strobe with no event present makes status 0 after that edge.
- R7: If an enabled event and a clear strobe occur at the same clock edge, status is 1 afterwards.
- R8: In level mode, status is set again at the clear edge itself while the active level is still present, so it never reads 0.
- R9: If the pin's {trigger bit, active-level field} differs from its value at the previous clock edge, status is 0 after that edge, even if an event occurs. The value before the first edge after reset counts as all zeros.
- R10: The first level sample after reset is never treated as an edge.
- R11: Pins are independent. The configuration, level and clear of one pin never affect another pin's status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_PINS | Filtered pin levels |
| trig_lvl | input | NUM_PINS | Trigger type per pin, 0 edge, 1 level |
| act_sel | input | 2*NUM_PINS | Active-level code per pin, bits [2p+1:2p] for pin p |
| irq_en | input | NUM_PINS | Detection enable per pin |
| irq_unmask | input | NUM_PINS | Request mask per pin, 1 passes the request |
| sts_clr | input | NUM_PINS | Write-one status clear strobe per pin |
| irq_sts | output | NUM_PINS | Sticky status per pin |
| irq_req | output | NUM_PINS | Interrupt request per pin |

## Verification
The bench sweeps all 32 combinations of trigger bit, active-level code, enable and mask across the pins, with each pin on a different level pattern and a different clear phase. A design that decodes code 10 as a level, or code 11 as anything, sets status where none should appear. A design that lets clear beat a simultaneous set drops an edge, and one that skips the configuration-change clear keeps stale status after reprogramming. Directed cases cover three more faults: a pin held high through reset would register a false rising edge, a masked pin would lose its status, and a level-mode clear could appear to take effect while the level is still active.

// File: rtl/gpio_irq_pkg.sv
// Package: shared sense-configuration types and active-level codes for the
// pin interrupt detector. Assumes a two-bit active-level field per pin.
package gpio_irq_pkg;

    localparam int ACT_W = 2;

    localparam logic [ACT_W-1:0] ACT_LOW_FALL = 2'b00;
    localparam logic [ACT_W-1:0] ACT_HIGH_RISE = 2'b01;
    localparam logic [ACT_W-1:0] ACT_ANY_EDGE = 2'b10;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        trig_e             trig;
        logic [ACT_W-1:0]  act;
    } sense_cfg_t;

endpackage

// File: rtl/gpio_irq_edge.sv
// Module: registers the previous level sample of one pin and flags rising
// and falling edges. Assumes the input is already synchronous to clk.
// No edge is reported until one sample has been taken after reset.
module gpio_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;
    logic primed_q;

    // Hold the last sample and note that a valid sample exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= lvl_i;
            primed_q <= 1'b1;
        end
    end

    // Compare the current level with the held one.
    always_comb begin
        rise_o = primed_q &  lvl_i & ~prev_q;
        fall_o = primed_q & ~lvl_i &  prev_q;
    end

    AST_NO_EDGE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !(rise_o || fall_o)); // R10

endmodule

// File: rtl/gpio_irq_sense.sv
// Module: decodes the sense configuration of one pin into a single hit
// signal from the level and the edge flags. Purely combinational.
// Undefined codes never produce a hit.
module gpio_irq_sense
    import gpio_irq_pkg::*;
(
    input  sense_cfg_t cfg_i,
    input  logic       lvl_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       hit_o
);

    // Select the event that counts for the configured trigger type and code.
    always_comb begin
        hit_o = 1'b0;
        if (cfg_i.trig == TRIG_LEVEL) begin
            case (cfg_i.act)
                ACT_LOW_FALL:  hit_o = ~lvl_i;
                ACT_HIGH_RISE: hit_o =  lvl_i;
                default:       hit_o = 1'b0;
            endcase
        end else begin
            case (cfg_i.act)
                ACT_LOW_FALL:  hit_o = fall_i;
                ACT_HIGH_RISE: hit_o = rise_i;
                ACT_ANY_EDGE:  hit_o = rise_i | fall_i;
                default:       hit_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_cell.sv
// Module: full interrupt detection for one pin: edge extraction, sense
// decode, configuration-change detection and the sticky status bit.
// Assumes clear strobes are single-cycle and configuration is synchronous.
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  sense_cfg_t cfg_i,
    input  logic       en_i,
    input  logic       unmask_i,
    input  logic       clr_i,
    output logic       sts_o,
    output logic       req_o
);

    logic       rise;
    logic       fall;
    logic       hit;
    logic       cfg_chg;
    sense_cfg_t cfg_q;
    logic       sts_q;

    gpio_irq_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_irq_sense u_sense (
        .cfg_i  (cfg_i),
        .lvl_i  (lvl_i),
        .rise_i (rise),
        .fall_i (fall),
        .hit_o  (hit)
    );

    // Remember the configuration seen at the last edge to spot reprogramming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_i;
        end
    end

    assign cfg_chg = (cfg_i != cfg_q);

    // Sticky status: reprogramming clears, an enabled hit sets, clear drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (cfg_chg) begin
            sts_q <= 1'b0;
        end else if (en_i && hit) begin
            sts_q <= 1'b1;
        end else if (clr_i) begin
            sts_q <= 1'b0;
        end
    end

    assign sts_o = sts_q;
    assign req_o = sts_q & unmask_i;

    AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o) |-> $past(en_i)); // R4
    AST_CFG_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !sts_o); // R9
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && !clr_i && !cfg_chg) |=> sts_o); // R6
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hit && clr_i && !cfg_chg) |=> sts_o); // R7
    AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.trig == TRIG_LEVEL && cfg_i.act == ACT_HIGH_RISE && lvl_i
         && en_i && !cfg_chg) |=> sts_o); // R8

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: top of the pin interrupt detector, one detection cell per pin.
// Assumes all inputs are synchronous to clk; pin levels are pre-filtered.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pin_lvl,
    input  logic [NUM_PINS-1:0]       trig_lvl,
    input  logic [ACT_W*NUM_PINS-1:0] act_sel,
    input  logic [NUM_PINS-1:0]       irq_en,
    input  logic [NUM_PINS-1:0]       irq_unmask,
    input  logic [NUM_PINS-1:0]       sts_clr,
    output logic [NUM_PINS-1:0]       irq_sts,
    output logic [NUM_PINS-1:0]       irq_req
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        sense_cfg_t cfg;

        // Gather this pin's trigger bit and active-level code.
        always_comb begin
            cfg.trig = trig_e'(trig_lvl[p]);
            cfg.act  = act_sel[ACT_W*p +: ACT_W];
        end

        gpio_irq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_i    (pin_lvl[p]),
            .cfg_i    (cfg),
            .en_i     (irq_en[p]),
            .unmask_i (irq_unmask[p]),
            .clr_i    (sts_clr[p]),
            .sts_o    (irq_sts[p]),
            .req_o    (irq_req[p])
        );

        AST_REQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[p] |-> (irq_unmask[p] && irq_sts[p])); // R5
        AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_sts[p] && irq_unmask[p]) |-> irq_req[p]); // R5
    end

endmodule

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_lvl = '0;
    logic [N-1:0] trig_lvl = '0;
    logic [2*N-1:0] act_sel = '0;
    logic [N-1:0] irq_en = '0;
    logic [N-1:0] irq_unmask = '0;
    logic [N-1:0] sts_clr = '0;
    logic [N-1:0] irq_sts;
    logic [N-1:0] irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state, per pin
    logic m_prev [N];
    logic m_primed [N];
    logic [2:0] m_cfg [N];
    logic m_sts [N];

    always #4 clk = ~clk;

    gpio_irq_detect #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_lvl(trig_lvl),
        .act_sel(act_sel), .irq_en(irq_en), .irq_unmask(irq_unmask),
        .sts_clr(sts_clr), .irq_sts(irq_sts), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0t got=%0b exp=%0b", tag, $time, got, exp);
        end
    endtask

    // advance the model by one clock edge, from requirement behaviour
    task automatic model_edge();
        for (int p = 0; p < N; p++) begin
            logic [2:0] cfg_now;
            logic r, f, hit, lv;
            logic [1:0] a;
            if (!rst_n) begin
                m_prev[p] = 0; m_primed[p] = 0; m_cfg[p] = 0; m_sts[p] = 0;
            end else begin
                lv = pin_lvl[p];
                a = act_sel[2*p +: 2];
                cfg_now = {trig_lvl[p], a};
                r = m_primed[p] && lv && !m_prev[p];
                f = m_primed[p] && !lv && m_prev[p];
                if (trig_lvl[p])
                    hit = (a == 2'd0 && !lv) || (a == 2'd1 && lv);
                else
                    hit = (a == 2'd0 && f) || (a == 2'd1 && r) || (a == 2'd2 && (r || f));
                if (cfg_now != m_cfg[p]) m_sts[p] = 0;
                else if (irq_en[p] && hit) m_sts[p] = 1;
                else if (sts_clr[p]) m_sts[p] = 0;
                m_prev[p] = lv; m_primed[p] = 1; m_cfg[p] = cfg_now;
            end
        end
    endtask

    // one clock: edge, model update, then compare at the falling edge
    task automatic cyc(input bit cmp);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (cmp) begin
            for (int p = 0; p < N; p++) begin
                check(trig_lvl[p] ? "R3 sts" : "R2 sts", irq_sts[p], m_sts[p]);
                check("R5 req", irq_req[p], m_sts[p] & irq_unmask[p]);
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(1'b0);
        cyc(1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1 sts after reset", |irq_sts, 1'b0);
        check("R1 req after reset", |irq_req, 1'b0);
        // sweep: every pin runs a different config and level pattern (R11)
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < N; p++) begin
                int k;
                k = (c + p * 9) % 32;
                trig_lvl[p] = k[4];
                act_sel[2*p +: 2] = k[3:2];
                irq_en[p] = k[1];
                irq_unmask[p] = k[0];
            end
            for (int t = 0; t < 24; t++) begin
                for (int p = 0; p < N; p++) begin
                    pin_lvl[p] = ((t * (p + 3) + (t >> 2)) >> 1) & 1;
                    sts_clr[p] = ((t + p) % 6) == 0;
                end
                cyc(1'b1);
            end
        end
        sts_clr = '0;

        // R10: pin held high through reset, rising-edge mode enabled
        pin_lvl = '1; trig_lvl = '0; act_sel = {N{2'b01}}; irq_en = '1; irq_unmask = '1;
        do_reset();
        cyc(1'b1);
        check("R10 no edge on first sample", irq_sts[0], 1'b0);
        cyc(1'b1);
        check("R1 quiet after reset", irq_req[0], 1'b0);
        // R9 first cycle with code 01 cleared nothing harmful; now a rising edge
        pin_lvl = '0; cyc(1'b1);
        pin_lvl = '1; cyc(1'b1);
        check("R2 rising edge sets", irq_sts[0], 1'b1);
        // R6: sticky after level returns low
        pin_lvl = '0; cyc(1'b1); cyc(1'b1);
        check("R6 sticky", irq_sts[0], 1'b1);
        // R5: mask blocks request only
        irq_unmask[0] = 1'b0; #1;
        check("R5 masked req", irq_req[0], 1'b0);
        check("R5 masked sts kept", irq_sts[0], 1'b1);
        irq_unmask[0] = 1'b1; #1;
        check("R5 unmasked req", irq_req[0], 1'b1);
        // R6: clear strobe drops status
        sts_clr[0] = 1'b1; cyc(1'b1); sts_clr[0] = 1'b0;
        check("R6 clear", irq_sts[0], 1'b0);
        // R7: rising edge and clear in the same cycle
        pin_lvl[0] = 1'b1; sts_clr[0] = 1'b1; cyc(1'b1); sts_clr[0] = 1'b0;
        check("R7 set wins", irq_sts[0], 1'b1);
        // R9: reprogram to any-edge while a falling edge arrives
        act_sel[1:0] = 2'b10; pin_lvl[0] = 1'b0; cyc(1'b1);
        check("R9 cfg change clears", irq_sts[0], 1'b0);
        check("R9 cfg change drops req", irq_req[0], 1'b0);
        // R4: disabled pin ignores edges
        irq_en[0] = 1'b0; pin_lvl[0] = 1'b1; cyc(1'b1);
        check("R4 disabled no set", irq_sts[0], 1'b0);
        irq_en[0] = 1'b1;
        // R8: level-high mode, clear while still high
        trig_lvl[0] = 1'b1; act_sel[1:0] = 2'b01; cyc(1'b1); cyc(1'b1);
        check("R3 level high sets", irq_sts[0], 1'b1);
        sts_clr[0] = 1'b1; cyc(1'b1); sts_clr[0] = 1'b0;
        check("R8 level re-asserts", irq_sts[0], 1'b1);
        pin_lvl[0] = 1'b0; sts_clr[0] = 1'b1; cyc(1'b1); sts_clr[0] = 1'b0;
        check("R8 clear once level gone", irq_sts[0], 1'b0);
        check("R11 other pin untouched", irq_sts[1], m_sts[1]);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule